// File: doc/BRIEF.md
# Software Trap and Return Sequencer

This block is the multi-cycle engine an 8-bit CPU uses to enter a software trap and to leave it again. A trap request carries an 8-bit vector number. The sequencer does four things in order. It saves the current 16-bit program counter and the flags byte on a byte-wide stack in data memory. It reads a two-byte target address from a table in program memory. It then hands that address back as the new program counter. A return request undoes the save: it pops the flags and the program counter, and it always turns interrupts on.

The CPU keeps its own stack pointer, program counter, flags and interrupt-enable registers. The sequencer samples the current values when it accepts a request. It updates those registers through write strobes that are high for exactly one cycle.

Both memory ports have a read latency of one cycle: data requested in one cycle is on the read bus in the next. A `busy` output tells the pipeline to hold off until the sequence is complete.

Top module: `trap_seq`

## Requirements
- R1: When a trap is accepted with stack pointer S, three data-memory writes follow on consecutive cycles:
  - program-counter high byte to S-2;
  - program-counter low byte to S-1;
  - flags byte to S-3.
  All stack arithmetic wraps modulo 2^16.
- R2: After the pushes, the trap reads program memory at 2×V (high byte of the target) and then at 2×V+1 (low byte), where V is the vector number. V runs from 0 to 255, so every table access lies between 0x000 and 0x1FF.
- R3: The trap ends with one `pc_wr` pulse. It carries `pc_nxt` = {byte at 2×V, byte at 2×V+1}, together with `sp_wr` and `sp_nxt` = S-3.
- R4: A trap does not pulse `flags_wr` and does not pulse `ie_set`.
- R5: When a return is accepted with stack pointer S:
  - it reads the flags at S, the program-counter high byte at S+1 and the low byte at S+2;
  - it then restores `pc_nxt` and `flags_nxt` from those bytes;
  - it writes `sp_nxt` = S+3.
  A trap followed by a return therefore leaves the program counter, flags and stack pointer as they were before the trap.
- R6: The last cycle of every return pulses `ie_set`, whatever the interrupt-enable state was before.
- R7: `busy` rises on the clock edge that accepts a request and stays high up to and including the cycle of the `pc_wr` pulse. That is 6 cycles for a trap and 4 for a return.
- R8: Trap and return requests that arrive while `busy` is high are ignored. They do not change the target, the stacked bytes or the sequence length.
- R9: If trap and return requests arrive in the same idle cycle, the trap is performed and the return is dropped.
- R10: While reset is held, `busy` is low and every memory strobe and register write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Start a software trap |
| trap_vec | input | 8 | Vector number for the trap |
| ret_req | input | 1 | Start a return from trap |
| busy | output | 1 | Sequence in progress |
| sp_cur | input | 16 | Current stack pointer |
| pc_cur | input | 16 | Current program counter |
| flags_cur | input | 8 | Current flags byte |
| sp_wr | output | 1 | Stack pointer write strobe |
| sp_nxt | output | 16 | New stack pointer |
| pc_wr | output | 1 | Program counter write strobe |
| pc_nxt | output | 16 | New program counter |
| flags_wr | output | 1 | Flags write strobe |
| flags_nxt | output | 8 | New flags byte |
| ie_set | output | 1 | Set the interrupt-enable bit |
| dm_addr | output | 16 | Data-memory address |
| dm_we | output | 1 | Data-memory write enable |
| dm_re | output | 1 | Data-memory read enable |
| dm_wdata | output | 8 | Data-memory write data |
| dm_rdata | input | 8 | Data-memory read data, one cycle after `dm_re` |
| pm_addr | output | 16 | Program-memory address |
| pm_re | output | 1 | Program-memory read enable |
| pm_rdata | input | 8 | Program-memory read data, one cycle after `pm_re` |

## Verification
The hardest situation to create from the ports is a new request arriving while a sequence is running. The bench holds a return request and a second trap with a different vector during the middle of a trap. It then checks that the final target, the stacked bytes and the cycle count all belong to the first trap.

A second hard case is a stack frame that straddles the address wrap. The bench drives this from a vector row with stack pointer 0x0001 and from a return row with stack pointer 0xFFFE.

A final directed test runs a trap and then a return with interrupts disabled. It shows that the return enables interrupts and restores the whole context.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int BYTE_W  = 8;
    localparam int PC_W    = 2 * BYTE_W;
    // Stack offsets below the entry stack pointer for each pushed byte.
    localparam int PCH_OFS = 2;
    localparam int PCL_OFS = 1;
    localparam int FLG_OFS = 3;
    localparam int FRAME_B = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_TRAP,
        OP_RET
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PSH_PCH,
        ST_PSH_PCL,
        ST_PSH_FLG,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_TRAP_DONE,
        ST_POP_FLG,
        ST_POP_PCH,
        ST_POP_PCL,
        ST_RET_DONE
    } seq_state_e;

    // Bytes held for the length of one sequence.
    typedef struct packed {
        byte_t pc_hi;
        byte_t pc_lo;
        byte_t flags;
        byte_t tgt_hi;
        byte_t pop_flags;
        byte_t pop_pch;
    } frame_t;

    // The trap wins when both requests arrive together.
    function automatic op_e pick_op(input logic trap, input logic ret);
        if (trap)
            return OP_TRAP;
        else if (ret)
            return OP_RET;
        else
            return OP_NONE;
    endfunction

    function automatic seq_state_e step(input seq_state_e s, input op_e op);
        case (s)
            ST_IDLE: begin
                case (op)
                    OP_TRAP: return ST_PSH_PCH;
                    OP_RET:  return ST_POP_FLG;
                    default: return ST_IDLE;
                endcase
            end
            ST_PSH_PCH:   return ST_PSH_PCL;
            ST_PSH_PCL:   return ST_PSH_FLG;
            ST_PSH_FLG:   return ST_VEC_HI;
            ST_VEC_HI:    return ST_VEC_LO;
            ST_VEC_LO:    return ST_TRAP_DONE;
            ST_POP_FLG:   return ST_POP_PCH;
            ST_POP_PCH:   return ST_POP_PCL;
            ST_POP_PCL:   return ST_RET_DONE;
            default:      return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/trap_arb.sv
module trap_arb
    import trap_pkg::*;
(
    input  logic       idle,
    input  logic       trap_req,
    input  logic       ret_req,
    output op_e        start_op
);
    // Requests only count while the sequencer is idle.
    always_comb begin
        start_op = OP_NONE;
        if (idle)
            start_op = pick_op(trap_req, ret_req);
    end
endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
    import trap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  op_e        start_op,
    output seq_state_e state,
    output logic       accept,
    output logic       idle
);
    seq_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= step(state_q, start_op);
    end

    always_comb begin
        state  = state_q;
        idle   = (state_q == ST_IDLE);
        accept = idle && (start_op != OP_NONE);
    end
endmodule

// File: rtl/trap_ctx.sv
module trap_ctx
    import trap_pkg::*;
#(
    parameter int AW    = 16,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  seq_state_e       state,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic [AW-1:0]    sp_cur,
    input  logic [PC_W-1:0]  pc_cur,
    input  byte_t            flags_cur,
    input  byte_t            dm_rdata,
    input  byte_t            pm_rdata,
    output logic [AW-1:0]    sp_q,
    output logic [VEC_W-1:0] vec_q,
    output frame_t           frm_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= '0;
            vec_q <= '0;
            frm_q <= '0;
        end else begin
            if (accept) begin
                sp_q        <= sp_cur;
                vec_q       <= trap_vec;
                frm_q.pc_hi <= pc_cur[PC_W-1:BYTE_W];
                frm_q.pc_lo <= pc_cur[BYTE_W-1:0];
                frm_q.flags <= flags_cur;
            end
            // Each read returns data one cycle after it is issued.
            case (state)
                ST_VEC_LO:  frm_q.tgt_hi    <= pm_rdata;
                ST_POP_PCH: frm_q.pop_flags <= dm_rdata;
                ST_POP_PCL: frm_q.pop_pch   <= dm_rdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/trap_port.sv
module trap_port
    import trap_pkg::*;
#(
    parameter int AW    = 16,
    parameter int VEC_W = 8,
    parameter int PM_AW = 16
) (
    input  seq_state_e       state,
    input  logic [AW-1:0]    sp_q,
    input  logic [VEC_W-1:0] vec_q,
    input  frame_t           frm_q,
    input  byte_t            dm_rdata,
    input  byte_t            pm_rdata,
    output logic             sp_wr,
    output logic [AW-1:0]    sp_nxt,
    output logic             pc_wr,
    output logic [PC_W-1:0]  pc_nxt,
    output logic             flags_wr,
    output byte_t            flags_nxt,
    output logic             ie_set,
    output logic [AW-1:0]    dm_addr,
    output logic             dm_we,
    output logic             dm_re,
    output byte_t            dm_wdata,
    output logic [PM_AW-1:0] pm_addr,
    output logic             pm_re
);
    localparam int TBL_AW = VEC_W + 1;

    function automatic logic [PM_AW-1:0] tbl_addr(input logic [VEC_W-1:0] v,
                                                   input logic lo);
        logic [TBL_AW-1:0] a;
        a = {v, lo};
        return PM_AW'(a);
    endfunction

    always_comb begin
        sp_wr     = 1'b0;
        sp_nxt    = '0;
        pc_wr     = 1'b0;
        pc_nxt    = '0;
        flags_wr  = 1'b0;
        flags_nxt = '0;
        ie_set    = 1'b0;
        dm_addr   = '0;
        dm_we     = 1'b0;
        dm_re     = 1'b0;
        dm_wdata  = '0;
        pm_addr   = '0;
        pm_re     = 1'b0;
        case (state)
            ST_PSH_PCH: begin
                dm_we    = 1'b1;
                dm_addr  = sp_q - AW'(PCH_OFS);
                dm_wdata = frm_q.pc_hi;
            end
            ST_PSH_PCL: begin
                dm_we    = 1'b1;
                dm_addr  = sp_q - AW'(PCL_OFS);
                dm_wdata = frm_q.pc_lo;
            end
            ST_PSH_FLG: begin
                dm_we    = 1'b1;
                dm_addr  = sp_q - AW'(FLG_OFS);
                dm_wdata = frm_q.flags;
            end
            ST_VEC_HI: begin
                pm_re   = 1'b1;
                pm_addr = tbl_addr(vec_q, 1'b0);
            end
            ST_VEC_LO: begin
                pm_re   = 1'b1;
                pm_addr = tbl_addr(vec_q, 1'b1);
            end
            ST_TRAP_DONE: begin
                pc_wr  = 1'b1;
                pc_nxt = {frm_q.tgt_hi, pm_rdata};
                sp_wr  = 1'b1;
                sp_nxt = sp_q - AW'(FRAME_B);
            end
            ST_POP_FLG: begin
                dm_re   = 1'b1;
                dm_addr = sp_q;
            end
            ST_POP_PCH: begin
                dm_re   = 1'b1;
                dm_addr = sp_q + AW'(1);
            end
            ST_POP_PCL: begin
                dm_re   = 1'b1;
                dm_addr = sp_q + AW'(2);
            end
            ST_RET_DONE: begin
                pc_wr     = 1'b1;
                pc_nxt    = {frm_q.pop_pch, dm_rdata};
                flags_wr  = 1'b1;
                flags_nxt = frm_q.pop_flags;
                ie_set    = 1'b1;
                sp_wr     = 1'b1;
                sp_nxt    = sp_q + AW'(FRAME_B);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_pkg::*;
#(
    parameter int AW    = 16,
    parameter int VEC_W = 8,
    parameter int PM_AW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trap_req,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic             ret_req,
    output logic             busy,
    input  logic [AW-1:0]    sp_cur,
    input  logic [15:0]      pc_cur,
    input  logic [7:0]       flags_cur,
    output logic             sp_wr,
    output logic [AW-1:0]    sp_nxt,
    output logic             pc_wr,
    output logic [15:0]      pc_nxt,
    output logic             flags_wr,
    output logic [7:0]       flags_nxt,
    output logic             ie_set,
    output logic [AW-1:0]    dm_addr,
    output logic             dm_we,
    output logic             dm_re,
    output logic [7:0]       dm_wdata,
    input  logic [7:0]       dm_rdata,
    output logic [PM_AW-1:0] pm_addr,
    output logic             pm_re,
    input  logic [7:0]       pm_rdata
);
    op_e              start_op;
    seq_state_e       state;
    logic             accept;
    logic             idle;
    logic [AW-1:0]    sp_q;
    logic [VEC_W-1:0] vec_q;
    frame_t           frm_q;

    trap_arb u_arb (
        .idle     (idle),
        .trap_req (trap_req),
        .ret_req  (ret_req),
        .start_op (start_op)
    );

    trap_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_op (start_op),
        .state    (state),
        .accept   (accept),
        .idle     (idle)
    );

    trap_ctx #(.AW(AW), .VEC_W(VEC_W)) u_ctx (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .state     (state),
        .trap_vec  (trap_vec),
        .sp_cur    (sp_cur),
        .pc_cur    (pc_cur),
        .flags_cur (flags_cur),
        .dm_rdata  (dm_rdata),
        .pm_rdata  (pm_rdata),
        .sp_q      (sp_q),
        .vec_q     (vec_q),
        .frm_q     (frm_q)
    );

    trap_port #(.AW(AW), .VEC_W(VEC_W), .PM_AW(PM_AW)) u_port (
        .state     (state),
        .sp_q      (sp_q),
        .vec_q     (vec_q),
        .frm_q     (frm_q),
        .dm_rdata  (dm_rdata),
        .pm_rdata  (pm_rdata),
        .sp_wr     (sp_wr),
        .sp_nxt    (sp_nxt),
        .pc_wr     (pc_wr),
        .pc_nxt    (pc_nxt),
        .flags_wr  (flags_wr),
        .flags_nxt (flags_nxt),
        .ie_set    (ie_set),
        .dm_addr   (dm_addr),
        .dm_we     (dm_we),
        .dm_re     (dm_re),
        .dm_wdata  (dm_wdata),
        .pm_addr   (pm_addr),
        .pm_re     (pm_re)
    );

    assign busy = !idle;
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
    parameter int AW    = 16,
    parameter int PM_AW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             dm_we,
    input logic             dm_re,
    input logic [AW-1:0]    dm_addr,
    input logic             pm_re,
    input logic [PM_AW-1:0] pm_addr,
    input logic             pc_wr,
    input logic             flags_wr,
    input logic             ie_set
);
    logic [3:0] acc_cnt;
    logic       saw_we;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            acc_cnt <= '0;
            saw_we  <= 1'b0;
        end else begin
            if (dm_we || dm_re || pm_re)
                acc_cnt <= acc_cnt + 4'd1;
            if (dm_we)
                saw_we <= 1'b1;
        end
    end

    // R1: the low program-counter byte goes one address above the high byte.
    p_pcl_above_pch_r1: assert property (@(posedge clk) disable iff (rst)
        dm_we && $past(dm_we) && !$past(dm_we, 2) |-> dm_addr == $past(dm_addr) + AW'(1));

    // R1: the flags byte goes one address below the high program-counter byte.
    p_flags_below_r1: assert property (@(posedge clk) disable iff (rst)
        dm_we && $past(dm_we) && $past(dm_we, 2) |-> dm_addr == $past(dm_addr, 2) - AW'(1));

    // R2: the table read starts at an even address inside the table.
    p_vec_even_r2: assert property (@(posedge clk) disable iff (rst)
        pm_re && !$past(pm_re) |-> !pm_addr[0] && (pm_addr < PM_AW'(512)));

    // R2: the low byte of the target is read at the next address.
    p_vec_pair_r2: assert property (@(posedge clk) disable iff (rst)
        pm_re && $past(pm_re) |-> pm_addr == $past(pm_addr) + PM_AW'(1));

    // R4: a sequence that wrote the stack neither loads flags nor enables interrupts.
    p_trap_keeps_ie_r4: assert property (@(posedge clk) disable iff (rst)
        pc_wr && saw_we |-> !flags_wr && !ie_set);

    // R6: the interrupt enable is set only together with the restore of the flags.
    p_ie_with_restore_r6: assert property (@(posedge clk) disable iff (rst)
        ie_set |-> pc_wr && flags_wr);

    // R7: the program counter is written only while busy, and busy ends right after that write.
    p_pcwr_busy_r7: assert property (@(posedge clk) disable iff (rst)
        pc_wr |-> busy);
    p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(pc_wr));

    // R8: no sequence makes more memory accesses than a single trap.
    p_access_bound_r8: assert property (@(posedge clk) disable iff (rst)
        acc_cnt <= 4'd5);

    // R10: the data port never reads and writes in the same cycle.
    p_port_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(dm_we && dm_re));
endmodule

bind trap_seq trap_seq_chk #(.AW(AW), .PM_AW(PM_AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .dm_we    (dm_we),
    .dm_re    (dm_re),
    .dm_addr  (dm_addr),
    .pm_re    (pm_re),
    .pm_addr  (pm_addr),
    .pc_wr    (pc_wr),
    .flags_wr (flags_wr),
    .ie_set   (ie_set)
);

// File: tb/sim_trap_seq.sv
module sim_trap_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_req = 1'b0;
    logic [7:0]  trap_vec = '0;
    logic        ret_req = 1'b0;
    logic        busy;
    logic [15:0] cpu_sp = '0;
    logic [15:0] cpu_pc = '0;
    logic [7:0]  cpu_fl = '0;
    logic        cpu_ie = 1'b0;
    logic        sp_wr, pc_wr, flags_wr, ie_set, dm_we, dm_re, pm_re;
    logic [15:0] sp_nxt, pc_nxt, dm_addr, pm_addr;
    logic [7:0]  flags_nxt, dm_wdata;
    logic [7:0]  dm_rdata = '0;
    logic [7:0]  pm_rdata = '0;

    logic [7:0]  dmem [1024];
    logic [7:0]  pmem [1024];
    logic [15:0] pm_a0 = '0, pm_a1 = '0;
    int          ie_cnt = 0, fw_cnt = 0;
    int          n_vec = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    trap_seq u0 (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_vec(trap_vec),
        .ret_req(ret_req), .busy(busy), .sp_cur(cpu_sp), .pc_cur(cpu_pc),
        .flags_cur(cpu_fl), .sp_wr(sp_wr), .sp_nxt(sp_nxt), .pc_wr(pc_wr),
        .pc_nxt(pc_nxt), .flags_wr(flags_wr), .flags_nxt(flags_nxt),
        .ie_set(ie_set), .dm_addr(dm_addr), .dm_we(dm_we), .dm_re(dm_re),
        .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .pm_addr(pm_addr),
        .pm_re(pm_re), .pm_rdata(pm_rdata)
    );

    // Memories with one-cycle read latency, plus the CPU register model.
    always @(posedge clk) begin
        if (dm_we) dmem[dm_addr[9:0]] <= dm_wdata;
        if (dm_re) dm_rdata <= dmem[dm_addr[9:0]];
        if (pm_re) begin
            pm_rdata <= pmem[pm_addr[9:0]];
            pm_a0    <= pm_a1;
            pm_a1    <= pm_addr;
        end
        if (sp_wr) cpu_sp <= sp_nxt;
        if (pc_wr) cpu_pc <= pc_nxt;
        if (flags_wr) begin
            cpu_fl <= flags_nxt;
            fw_cnt <= fw_cnt + 1;
        end
        if (ie_set) begin
            cpu_ie <= 1'b1;
            ie_cnt <= ie_cnt + 1;
        end
    end

    function automatic logic [7:0] pm_byte(input int a);
        return 8'(a * 29 + 91) ^ 8'(a >> 3);
    endfunction

    function automatic logic [15:0] tgt(input logic [7:0] v);
        return {pm_byte(2 * int'(v)), pm_byte(2 * int'(v) + 1)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issue a request at a falling edge and count the busy cycles.
    task automatic run_op(input bit tr, input bit rt, input logic [7:0] v, output int cyc);
        @(negedge clk);
        trap_req = tr;
        ret_req  = rt;
        trap_vec = v;
        @(posedge clk);
        #1;
        trap_req = 1'b0;
        ret_req  = 1'b0;
        cyc = 0;
        while (busy && cyc < 50) begin
            cyc++;
            @(posedge clk);
            #1;
        end
    endtask

    task automatic set_ctx(input logic [15:0] sp, input logic [15:0] pc,
                           input logic [7:0] fl, input logic ie);
        @(negedge clk);
        cpu_sp = sp;
        cpu_pc = pc;
        cpu_fl = fl;
        cpu_ie = ie;
    endtask

    // Row: {return, vector, stack pointer, program counter, flags}
    localparam logic [48:0] ROWS [8] = '{
        {1'b0, 8'd0,   16'h0200, 16'h1234, 8'hA5},
        {1'b0, 8'd255, 16'h0300, 16'hBEEF, 8'h3C},
        {1'b0, 8'd1,   16'h0001, 16'h00FF, 8'h80},
        {1'b0, 8'd128, 16'h0104, 16'hFFFF, 8'h00},
        {1'b1, 8'd0,   16'h0100, 16'h4321, 8'h5A},
        {1'b1, 8'd0,   16'hFFFE, 16'h8001, 8'hFF},
        {1'b0, 8'd77,  16'h0380, 16'h0000, 8'h11},
        {1'b1, 8'd0,   16'h0200, 16'h00AA, 8'h01}
    };

    initial begin
        #1_000_000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int cyc;
        int ie0, fw0;
        for (int i = 0; i < 1024; i++) begin
            dmem[i] = '0;
            pmem[i] = pm_byte(i);
        end
        repeat (3) @(posedge clk);
        #1;
        // R10: everything quiet while reset is held
        chk(!busy, "R10", "busy in reset", 32'(busy), 0);
        chk(!(dm_we || dm_re || pm_re), "R10", "mem strobes in reset",
            {29'd0, dm_we, dm_re, pm_re}, 0);
        chk(!(pc_wr || sp_wr || flags_wr || ie_set), "R10", "reg strobes in reset",
            {28'd0, pc_wr, sp_wr, flags_wr, ie_set}, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int r = 0; r < 8; r++) begin
            logic        is_ret;
            logic [7:0]  v, fl;
            logic [15:0] sp, pc;
            {is_ret, v, sp, pc, fl} = ROWS[r];
            if (!is_ret) begin
                set_ctx(sp, pc, fl, 1'b0);
                ie0 = ie_cnt;
                fw0 = fw_cnt;
                run_op(1'b1, 1'b0, v, cyc);
                chk(cyc == 6, "R7", "trap busy cycles", cyc, 6);
                chk(dmem[10'(sp - 16'd2)] == pc[15:8], "R1", "stacked pc high",
                    dmem[10'(sp - 16'd2)], pc[15:8]);
                chk(dmem[10'(sp - 16'd1)] == pc[7:0], "R1", "stacked pc low",
                    dmem[10'(sp - 16'd1)], pc[7:0]);
                chk(dmem[10'(sp - 16'd3)] == fl, "R1", "stacked flags",
                    dmem[10'(sp - 16'd3)], fl);
                chk(pm_a0 == {7'd0, v, 1'b0} && pm_a1 == {7'd0, v, 1'b1}, "R2",
                    "table addresses", {pm_a0, pm_a1}, {7'd0, v, 1'b0, 7'd0, v, 1'b1});
                chk(cpu_pc == tgt(v), "R3", "trap target", cpu_pc, tgt(v));
                chk(cpu_sp == sp - 16'd3, "R3", "trap stack pointer", cpu_sp, sp - 16'd3);
                chk(cpu_ie == 1'b0 && ie_cnt == ie0 && fw_cnt == fw0 && cpu_fl == fl,
                    "R4", "trap left ie and flags", {cpu_ie, cpu_fl}, {1'b0, fl});
            end else begin
                set_ctx(sp, 16'hDEAD, 8'h00, 1'b0);
                dmem[10'(sp)]          = fl;
                dmem[10'(sp + 16'd1)]  = pc[15:8];
                dmem[10'(sp + 16'd2)]  = pc[7:0];
                run_op(1'b0, 1'b1, 8'd0, cyc);
                chk(cyc == 4, "R7", "return busy cycles", cyc, 4);
                chk(cpu_pc == pc, "R5", "restored pc", cpu_pc, pc);
                chk(cpu_fl == fl, "R5", "restored flags", cpu_fl, fl);
                chk(cpu_sp == sp + 16'd3, "R5", "restored sp", cpu_sp, sp + 16'd3);
                chk(cpu_ie == 1'b1, "R6", "ie after return", cpu_ie, 1);
            end
        end

        // R8: requests during a running trap are ignored
        set_ctx(16'h0280, 16'h5566, 8'h77, 1'b0);
        @(negedge clk);
        trap_req = 1'b1;
        trap_vec = 8'd3;
        @(negedge clk);
        trap_req = 1'b0;
        @(negedge clk);
        trap_req = 1'b1;
        ret_req  = 1'b1;
        trap_vec = 8'd200;
        repeat (2) @(negedge clk);
        trap_req = 1'b0;
        ret_req  = 1'b0;
        cyc = 0;
        while (busy && cyc < 50) begin
            cyc++;
            @(negedge clk);
        end
        chk(cyc == 3, "R8", "remaining busy cycles", cyc, 3);
        chk(cpu_pc == tgt(8'd3), "R8", "target of first trap", cpu_pc, tgt(8'd3));
        chk(dmem[10'h27E] == 8'h55 && dmem[10'h27F] == 8'h66 && dmem[10'h27D] == 8'h77,
            "R8", "stack frame of first trap",
            {8'd0, dmem[10'h27E], dmem[10'h27F], dmem[10'h27D]}, 32'h556677);
        @(negedge clk);
        chk(!busy, "R8", "no queued sequence", 32'(busy), 0);

        // R9: both requests in one idle cycle perform the trap
        set_ctx(16'h0340, 16'hA1B2, 8'h42, 1'b0);
        ie0 = ie_cnt;
        run_op(1'b1, 1'b1, 8'd9, cyc);
        chk(cyc == 6, "R9", "trap length", cyc, 6);
        chk(cpu_pc == tgt(8'd9) && ie_cnt == ie0, "R9", "trap target", cpu_pc, tgt(8'd9));

        // R6: trap then return with interrupts off restores context and enables them
        set_ctx(16'h0180, 16'h7F01, 8'hC3, 1'b0);
        run_op(1'b1, 1'b0, 8'd64, cyc);
        run_op(1'b0, 1'b1, 8'd0, cyc);
        chk(cpu_pc == 16'h7F01 && cpu_fl == 8'hC3 && cpu_sp == 16'h0180, "R5",
            "round trip context", {cpu_pc, cpu_fl, cpu_sp[7:0]}, 32'h7F01C380);
        chk(cpu_ie == 1'b1, "R6", "ie after round trip", cpu_ie, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule